// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector with Lock Indicator

This block compares a divided feedback clock with a divided reference clock, both oversampled by a fast system clock. Each input passes through a synchronizer and a rising-edge detector. The edge events drive a two-flop tri-state detector. A reference edge that comes before the matching feedback edge raises the up correction output, which speeds up the oscillator. A feedback edge that comes first raises the down output, which slows the oscillator. The correction pulse lasts as long as the two edges are apart, measured in system clock cycles. When both flops are set, both clear on the next system clock.

A raw error window is formed as the NAND of the active-low forms of the two pulses, so it is high while either correction is active. A digital integrator watches this window. It raises the lock flag once a set number of consecutive reference periods pass with no long error run. It drops the flag on the first error run that reaches a set length. An output enable gates only the correction outputs. The window and the lock flag keep tracking while the outputs are disabled.

Top module: `pfd_lock_top`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, up_o, dn_o, win_o and lock_o are all 0.
- R2: When a feedback rising edge leads the reference rising edge by D system cycles (D >= 1), dn_o is high for exactly D+1 cycles, up_o is high for exactly 1 cycle, and that up_o cycle is the last cycle of dn_o.
- R3: When a reference rising edge leads the feedback rising edge by D cycles (D >= 1), up_o is high for exactly D+1 cycles and dn_o is high for exactly 1 cycle.
- R4: Rising edges on both inputs in the same cycle give exactly one cycle with up_o and dn_o both high, and no other pulse.
- R5: Only rising edges trigger the detector. Falling edges, and levels held steady, produce no pulse on up_o or dn_o.
- R6: up_o and dn_o are never both high in two consecutive cycles.
- R7: While out_en_i is 0, up_o and dn_o stay 0. win_o and lock_o keep responding to the inputs.
- R8: win_o is 1 exactly when the internal up or down state is set, that is, the NAND of the two active-low pulses. With out_en_i at 1, win_o is 1 in every cycle that up_o or dn_o is 1.
- R9: lock_o rises only in the cycle after a reference edge. It rises after LOCK_PERIODS consecutive reference edges (default 4) with no long error run.
- R10: An error run is a stretch of consecutive cycles with win_o at 1. A run that reaches LONG_ERR cycles (default 4) clears lock_o, and the period count restarts from zero.
- R11: Error runs shorter than LONG_ERR cycles leave lock_o unchanged.
- R12: When the feedback frequency is higher than the reference frequency, dn_o is high for more cycles than up_o over a full beat period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Divided reference clock |
| fb_i | input | 1 | Divided feedback clock |
| out_en_i | input | 1 | Enable for up_o and dn_o |
| up_o | output | 1 | Correction pulse that raises the oscillator frequency |
| dn_o | output | 1 | Correction pulse that lowers the oscillator frequency |
| win_o | output | 1 | Raw error window, high while either correction is active |
| lock_o | output | 1 | Filtered lock flag |

## Verification
The hardest case to reach from the ports is the frequency-error case. Here the faster feedback clock puts two of its edges between a pair of reference edges, so the down state must stay set across a feedback edge that does nothing. The bench reaches this case by running the two inputs at periods of 14 and 16 cycles for one full beat period and comparing total down and up cycles. The lock integrator is walked through its states with whole comparison periods at chosen edge offsets:
- sub-threshold runs, which must leave lock_o unchanged;
- a run that reaches the threshold, which must clear lock_o.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum int unsigned {
    CH_REF = 0,
    CH_FB  = 1
  } pfd_ch_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] lvl_i,
  output logic [N_CH-1:0] rise_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], lvl_i[c]};
        prev_q <= sh_q[STAGES-1];
      end
    end

    assign rise_o[c] = sh_q[STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic fb_rise_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q, both;

  assign both = up_q & dn_q;

  // clearing wins over a new edge in the overlap cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (both) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | ref_rise_i;
      dn_q <= dn_q | fb_rise_i;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
  parameter int unsigned LOCK_PERIODS = 4,
  parameter int unsigned LONG_ERR     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_i,
  input  logic period_i,
  output logic lock_o
);
  localparam int unsigned RUN_W  = $clog2(LONG_ERR + 1);
  localparam int unsigned GOOD_W = $clog2(LOCK_PERIODS + 1);

  logic [RUN_W-1:0]  run_q;
  logic [GOOD_W-1:0] good_q;
  logic              lock_q;
  logic              long_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           run_q <= '0;
    else if (!win_i)                       run_q <= '0;
    else if (run_q != RUN_W'(LONG_ERR))    run_q <= run_q + 1'b1;
  end

  assign long_err = win_i && (run_q >= RUN_W'(LONG_ERR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (long_err) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (period_i && good_q != GOOD_W'(LOCK_PERIODS)) begin
      good_q <= good_q + 1'b1;
      if (good_q == GOOD_W'(LOCK_PERIODS - 1)) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned LOCK_PERIODS = 4,
  parameter int unsigned LONG_ERR     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  input  logic out_en_i,
  output logic up_o,
  output logic dn_o,
  output logic win_o,
  output logic lock_o
);
  logic [NUM_CH-1:0] lvl, rise;
  logic ref_rise, fb_rise;
  logic up_raw, dn_raw;
  logic up_n, dn_n;

  assign lvl[CH_REF] = ref_i;
  assign lvl[CH_FB]  = fb_i;

  pfd_edge_sync #(.N_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .rise_o(rise)
  );

  assign ref_rise = rise[CH_REF];
  assign fb_rise  = rise[CH_FB];

  pfd_tristate u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_rise_i(ref_rise),
    .fb_rise_i (fb_rise),
    .up_o      (up_raw),
    .dn_o      (dn_raw)
  );

  // active-low pulse forms; window is their NAND
  assign up_n  = ~up_raw;
  assign dn_n  = ~dn_raw;
  assign win_o = ~(up_n & dn_n);

  pfd_lock_filter #(.LOCK_PERIODS(LOCK_PERIODS), .LONG_ERR(LONG_ERR)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .win_i   (win_o),
    .period_i(ref_rise),
    .lock_o  (lock_o)
  );

  assign up_o = up_raw & out_en_i;
  assign dn_o = dn_raw & out_en_i;
endmodule

// File: rtl/pfd_lock_checker.sv
module pfd_lock_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic out_en_i,
  input logic up_o,
  input logic dn_o,
  input logic win_o,
  input logic lock_o,
  input logic ref_rise,
  input logic up_raw
);
  p_no_double_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_raw && dn_o) |=> !(up_o && dn_o))
    else $error("R6 up and down high together twice");

  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> (!up_o && !dn_o))
    else $error("R7 output active while disabled");

  p_win_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && (up_o || dn_o)) |-> win_o)
    else $error("R8 window low during pulse");

  p_lock_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(ref_rise))
    else $error("R9 lock rose without reference edge");

  p_rise_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_raw) |-> $past(ref_rise))
    else $error("R5 up set without reference rising edge");
endmodule

bind pfd_lock_top pfd_lock_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .out_en_i(out_en_i),
  .up_o    (up_o),
  .dn_o    (dn_o),
  .win_o   (win_o),
  .lock_o  (lock_o),
  .ref_rise(ref_rise),
  .up_raw  (up_raw)
);

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;
  localparam int CLK_PERIOD = 10;
  localparam int PER        = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_s = 1'b0, fb_s = 1'b0, en = 1'b1;
  logic up, dn, win, lock;

  int n_chk = 0, n_err = 0;
  int upc, dnc, bothc, winc, maxboth;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_lock_top dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .fb_i(fb_s),
    .out_en_i(en), .up_o(up), .dn_o(dn), .win_o(win), .lock_o(lock)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_cnt();
    upc = 0; dnc = 0; bothc = 0; winc = 0; maxboth = 0;
  endtask

  task automatic sample(inout int run);
    if (up) upc++;
    if (dn) dnc++;
    if (win) winc++;
    if (up && dn) begin bothc++; run++; end else run = 0;
    if (run > maxboth) maxboth = run;
  endtask

  // one comparison period: leader edge at step 0, other edge at step off
  task automatic period(input bit ref_leads, input int off);
    int run = 0;
    clr_cnt();
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      sample(run);
      if (i == 0)   begin if (ref_leads) ref_s = 1'b1; else fb_s = 1'b1; end
      if (i == off) begin if (ref_leads) fb_s = 1'b1; else ref_s = 1'b1; end
      if (i == 11)  begin ref_s = 1'b0; fb_s = 1'b0; end
    end
  endtask

  task automatic do_reset();
    ref_s = 1'b0; fb_s = 1'b0; en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!up && !dn && !win && !lock, "R1 in reset", {up, dn, win, lock}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!up && !dn && !win && !lock, "R1 after release", {up, dn, win, lock}, 0);
  endtask

  task automatic t_fb_leads();
    period(1'b0, 3);
    check(dnc == 4, "R2 dn width", dnc, 4);
    check(upc == 1 && bothc == 1, "R2 up one overlap cycle", upc, 1);
    period(1'b0, 6);
    check(dnc == 7, "R2 dn width off6", dnc, 7);
  endtask

  task automatic t_ref_leads();
    period(1'b1, 2);
    check(upc == 3, "R3 up width", upc, 3);
    check(dnc == 1, "R3 dn one cycle", dnc, 1);
    check(maxboth <= 1, "R6 overlap run", maxboth, 1);
  endtask

  task automatic t_same();
    period(1'b1, 0);
    check(bothc == 1 && upc == 1 && dnc == 1, "R4 simultaneous", bothc, 1);
  endtask

  task automatic t_rise_only();
    int run = 0;
    period(1'b1, 0);
    @(negedge clk); ref_s = 1'b1; fb_s = 1'b1;
    repeat (8) @(negedge clk);
    clr_cnt();
    fb_s = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); sample(run); end
    ref_s = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); sample(run); end
    check(upc == 0 && dnc == 0, "R5 falling edges quiet", upc + dnc, 0);
  endtask

  task automatic t_enable();
    en = 1'b0;
    period(1'b1, 3);
    check(upc == 0 && dnc == 0, "R7 outputs held low", upc + dnc, 0);
    check(winc == 4, "R7 window still active", winc, 4);
    en = 1'b1;
    period(1'b1, 3);
    check(winc == upc && upc == 4, "R8 window tracks pulses", winc, 4);
  endtask

  task automatic t_lock();
    do_reset();
    for (int p = 0; p < 3; p++) period(1'b1, 0);
    check(!lock, "R9 not yet locked", lock, 0);
    period(1'b1, 0);
    check(lock, "R9 locked after periods", lock, 1);
    period(1'b1, 2);
    check(lock, "R11 short error keeps lock", lock, 1);
    period(1'b0, 3);
    check(!lock, "R10 long error clears lock", lock, 0);
    for (int p = 0; p < 3; p++) period(1'b1, 1);
    check(!lock, "R10 count restarted", lock, 0);
    period(1'b1, 1);
    check(lock, "R9 relock", lock, 1);
  endtask

  task automatic t_freq();
    int run = 0;
    do_reset();
    clr_cnt();
    for (int i = 0; i < 112; i++) begin
      @(negedge clk);
      sample(run);
      fb_s  = (i % 14) < 4;
      ref_s = (i % 16) < 4;
    end
    check(dnc > upc, "R12 fast feedback gives net down", dnc, upc + 1);
    check(maxboth <= 1, "R6 overlap under frequency error", maxboth, 1);
  endtask

  initial begin
    do_reset();
    t_fb_leads();
    t_ref_leads();
    t_same();
    t_rise_only();
    t_enable();
    t_lock();
    t_freq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule